// File: doc/BRIEF.md
# Indirect Peripheral Register File with Interrupt Latch

This block sits on the peripheral side of a narrow asynchronous host bus and offers the host a small set of registers. The bus has an active-low chip select, a read/write line (1 = read) and a single address line. When the address line is low, the host reaches a control register. When it is high, the host reaches one of three data registers. A two-bit field in the control register picks which data register that is. Access is therefore indirect: the host first writes the control register to choose a target, then reads or writes that target.

The control register also gates an interrupt. An internal event sets a pending latch, which pulls an open-drain, active-low interrupt line. Any access to the control register, read or write, acknowledges the interrupt. An enable bit in the control register is cleared by system reset, so the interrupt line cannot be pulled after reset until the host enables it. The bus inputs are asynchronous to the local clock. They pass through a synchronizer, and a write takes effect on the deasserting edge of chip select. Pad tri-state control is brought out as separate enable outputs.

Top module: `pregs_regfile`

## Requirements
- R1: After reset, the control register, all three data registers, `irq_pull` and `bus_d_oe` are all 0.
- R2: A write with `bus_a1`=0 loads the control register from data bits [3:0]: bit 0 = interrupt enable, bit 1 = auxiliary control (`mode_aux`), bits [3:2] = target select. Data bits [7:4] are dropped. A read with `bus_a1`=0 returns {4'b0, control register}.
- R3: A write with `bus_a1`=1 loads the data register whose index equals the select field (0, 1 or 2). The other data registers are unchanged. A read with `bus_a1`=1 returns that register. `data_regs` bits [8i+7:8i] carry register i.
- R4: When the select field is 3, a read with `bus_a1`=1 returns 0x00, and a write with `bus_a1`=1 changes no data register.
- R5: A write commits only after chip select rises. It uses the address, direction and data presented while chip select was low. A register is unchanged while chip select is still low, and bus data that changes after chip select rises does not affect the stored value.
- R6: `bus_d_oe` is 1 during a read cycle while chip select is low. It is 0 during write cycles and 0 once a cycle has ended.
- R7: With the enable bit set, a one-cycle `irq_event` pulse makes `irq_pull` 1. It stays 1 through idle time and through data-register reads and writes.
- R8: Any read or write of the control register clears a pending interrupt, so `irq_pull` returns to 0.
- R9: While the enable bit is 0, `irq_pull` stays 0. An event that arrives while the enable bit is 0 is not remembered once the bit is later set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| bus_cs_n | input | 1 | Chip select from host, active low, asynchronous |
| bus_rw | input | 1 | Direction from host: 1 = read, 0 = write |
| bus_a1 | input | 1 | Address line: 0 = control register, 1 = selected data register |
| bus_d_in | input | 8 | Data bus as received from the pad |
| bus_d_out | output | 8 | Read data toward the pad |
| bus_d_oe | output | 1 | Pad output enable for read data |
| irq_event | input | 1 | Internal interrupt source, one-cycle pulse |
| irq_pull | output | 1 | 1 = pull the open-drain interrupt line low |
| mode_aux | output | 1 | Auxiliary control bit of the control register |
| data_regs | output | 24 | Contents of the three data registers, register 0 in the low byte |

## Verification
Writes and reads are applied at each select value 0, 1, 2 and 3 with distinct byte patterns. A write landing in the wrong register, or an ignored code leaking into storage, therefore shows up as a wrong byte. Control-register writes use values with upper bits set, which separates field masking from plain storage. A write whose bus data is swapped for a different value just after chip select rises shows whether the captured value or the late value is stored. The register is also sampled mid-cycle to show that nothing commits early. Interrupt tests pend an event, then make data-register accesses (which must leave it pending) and control-register reads and writes (which must clear it). Events are also pulsed while disabled, which tells gating apart from a latch that remembers.

// File: rtl/pregs_pkg.sv
package pregs_pkg;

    localparam int SEL_W  = 2;
    localparam int MODE_W = 4;

    // Control register layout: bit0 enable, bit1 aux, bits[3:2] select
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             aux;
        logic             en;
    } mode_t;

endpackage

// File: rtl/pregs_bus_sync.sv
module pregs_bus_sync #(
    parameter int DATA_W = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rw,
    input  logic              a1,
    input  logic [DATA_W-1:0] d_in,
    output logic              cs_active,
    output logic              cs_rise,
    output logic              rw_h,
    output logic              a1_h,
    output logic [DATA_W-1:0] d_h
);

    localparam int W = DATA_W + 3;
    localparam logic [W-1:0] RST_VAL = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        logic              cs_prev;
        logic              rw;
        logic              a1;
        logic [DATA_W-1:0] d;
    } hold_t;

    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] raw;
    logic [W-1:0] synced;
    hold_t        h_d, h_q;

    assign raw = {cs_n, rw, a1, d_in};

    // Synchronizer chain: cs, direction, address and data travel together
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= raw;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= stg_q[g-1];
            end
        end
    end

    assign synced = stg_q[STAGES-1];

    always_comb begin
        h_d         = h_q;
        h_d.cs_prev = synced[W-1];
        if (!synced[W-1]) begin
            h_d.rw = synced[W-2];
            h_d.a1 = synced[W-3];
            h_d.d  = synced[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '{cs_prev: 1'b1, rw: 1'b0, a1: 1'b0, d: '0};
        else        h_q <= h_d;
    end

    assign cs_active = !synced[W-1] && !h_q.cs_prev;
    assign cs_rise   = synced[W-1] && !h_q.cs_prev;
    assign rw_h      = h_q.rw;
    assign a1_h      = h_q.a1;
    assign d_h       = h_q.d;

    // R5: a completed access yields exactly one commit strobe
    p_single_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !cs_rise);

endmodule

// File: rtl/pregs_irq.sv
module pregs_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic event_i,
    input  logic clear_i,
    output logic irq_pull
);

    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (clear_i)            pend_d = 1'b0;
        if (event_i && enable)  pend_d = 1'b1;
        if (!enable)            pend_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign irq_pull = pend_q && enable;

    p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pull && enable && !clear_i) |=> irq_pull);

    p_irq_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !event_i) |=> !irq_pull);

    p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !irq_pull);

endmodule

// File: rtl/pregs_regfile.sv
module pregs_regfile #(
    parameter int DATA_W      = 8,
    parameter int NUM_DATA    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_cs_n,
    input  logic                         bus_rw,
    input  logic                         bus_a1,
    input  logic [DATA_W-1:0]            bus_d_in,
    output logic [DATA_W-1:0]            bus_d_out,
    output logic                         bus_d_oe,
    input  logic                         irq_event,
    output logic                         irq_pull,
    output logic                         mode_aux,
    output logic [NUM_DATA*DATA_W-1:0]   data_regs
);

    import pregs_pkg::*;

    typedef struct packed {
        mode_t                              mode;
        logic [NUM_DATA-1:0][DATA_W-1:0]    regs;
    } state_t;

    state_t             st_d, st_q;
    logic               cs_active, cs_rise, rw_h, a1_h;
    logic [DATA_W-1:0]  d_h;
    logic               mode_touch;
    logic [DATA_W-1:0]  rd_data;

    pregs_bus_sync #(
        .DATA_W (DATA_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (bus_cs_n),
        .rw        (bus_rw),
        .a1        (bus_a1),
        .d_in      (bus_d_in),
        .cs_active (cs_active),
        .cs_rise   (cs_rise),
        .rw_h      (rw_h),
        .a1_h      (a1_h),
        .d_h       (d_h)
    );

    assign mode_touch = cs_rise && !a1_h;

    always_comb begin
        st_d = st_q;
        if (cs_rise && !rw_h) begin
            if (!a1_h) begin
                st_d.mode = mode_t'(d_h[MODE_W-1:0]);
            end else begin
                for (int i = 0; i < NUM_DATA; i++) begin
                    if (st_q.mode.sel == SEL_W'(i)) st_d.regs[i] = d_h;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        if (!a1_h) begin
            rd_data[MODE_W-1:0] = st_q.mode;
        end else begin
            for (int i = 0; i < NUM_DATA; i++) begin
                if (st_q.mode.sel == SEL_W'(i)) rd_data = st_q.regs[i];
            end
        end
    end

    assign bus_d_out = rd_data;
    assign bus_d_oe  = cs_active && rw_h;
    assign mode_aux  = st_q.mode.aux;
    assign data_regs = st_q.regs;

    pregs_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (st_q.mode.en),
        .event_i  (irq_event),
        .clear_i  (mode_touch),
        .irq_pull (irq_pull)
    );

    p_mode_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && !rw_h && !a1_h) |=> (st_q.mode == $past(d_h[MODE_W-1:0])));

    p_sel3_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && !rw_h && a1_h && st_q.mode.sel == SEL_W'(NUM_DATA)) |=> $stable(data_regs));

    p_write_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_active && !rw_h) |-> !bus_d_oe);

endmodule

// File: tb/pregs_regfile_test.sv
module pregs_regfile_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs_n = 1'b1;
    logic        bus_rw = 1'b1;
    logic        bus_a1 = 1'b0;
    logic [7:0]  bus_d_in = 8'h00;
    logic [7:0]  bus_d_out;
    logic        bus_d_oe;
    logic        irq_event = 1'b0;
    logic        irq_pull;
    logic        mode_aux;
    logic [23:0] data_regs;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pregs_regfile uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_cs_n  (bus_cs_n),
        .bus_rw    (bus_rw),
        .bus_a1    (bus_a1),
        .bus_d_in  (bus_d_in),
        .bus_d_out (bus_d_out),
        .bus_d_oe  (bus_d_oe),
        .irq_event (irq_event),
        .irq_pull  (irq_pull),
        .mode_aux  (mode_aux),
        .data_regs (data_regs)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a1, input logic [7:0] val);
        @(negedge clk);
        bus_rw = 1'b0; bus_a1 = a1; bus_d_in = val;
        @(negedge clk);
        bus_cs_n = 1'b0;
        repeat (25) @(negedge clk);
        bus_cs_n = 1'b1;
        @(negedge clk);
        bus_d_in = 8'hEE; bus_rw = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic bus_read(input logic a1, output logic [7:0] val, output logic oe);
        @(negedge clk);
        bus_rw = 1'b1; bus_a1 = a1;
        @(negedge clk);
        bus_cs_n = 1'b0;
        repeat (20) @(negedge clk);
        val = bus_d_out; oe = bus_d_oe;
        repeat (5) @(negedge clk);
        bus_cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic pulse_event();
        @(negedge clk);
        irq_event = 1'b1;
        @(negedge clk);
        irq_event = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v; logic oe;
        chk("R1 irq_pull", irq_pull, 0);
        chk("R1 oe", bus_d_oe, 0);
        chk("R1 aux", mode_aux, 0);
        chk("R1 data", data_regs, 0);
        bus_read(1'b0, v, oe);
        chk("R1 mode read", v, 8'h00);
    endtask

    task automatic t_mode();
        logic [7:0] v; logic oe;
        bus_write(1'b0, 8'h0E);
        bus_read(1'b0, v, oe);
        chk("R2 mode readback", v, 8'h0E);
        chk("R2 aux bit", mode_aux, 1);
        bus_write(1'b0, 8'hF5);
        bus_read(1'b0, v, oe);
        chk("R2 upper bits dropped", v, 8'h05);
        chk("R2 aux cleared", mode_aux, 0);
    endtask

    task automatic t_data();
        logic [7:0] v; logic oe;
        logic [7:0] pat [3] = '{8'hA1, 8'h5B, 8'hC3};
        for (int i = 0; i < 3; i++) begin
            bus_write(1'b0, 8'(i << 2));
            bus_write(1'b1, pat[i]);
        end
        chk("R3 data layout", data_regs, {8'hC3, 8'h5B, 8'hA1});
        for (int i = 0; i < 3; i++) begin
            bus_write(1'b0, 8'(i << 2));
            bus_read(1'b1, v, oe);
            chk("R3 data readback", v, pat[i]);
        end
        bus_write(1'b0, 8'h04);
        bus_write(1'b1, 8'h3C);
        chk("R3 single target", data_regs, {8'hC3, 8'h3C, 8'hA1});
    endtask

    task automatic t_sel3();
        logic [7:0] v; logic oe;
        bus_write(1'b0, 8'h0C);
        bus_write(1'b1, 8'h77);
        chk("R4 write ignored", data_regs, {8'hC3, 8'h3C, 8'hA1});
        bus_read(1'b1, v, oe);
        chk("R4 reads zero", v, 8'h00);
    endtask

    task automatic t_commit_edge();
        bus_write(1'b0, 8'h00);
        @(negedge clk);
        bus_rw = 1'b0; bus_a1 = 1'b1; bus_d_in = 8'h9D;
        @(negedge clk);
        bus_cs_n = 1'b0;
        repeat (12) @(negedge clk);
        chk("R5 no early commit", data_regs[7:0], 8'hA1);
        chk("R6 no drive on write", bus_d_oe, 0);
        repeat (13) @(negedge clk);
        bus_cs_n = 1'b1;
        @(negedge clk);
        bus_d_in = 8'h11;
        repeat (6) @(negedge clk);
        chk("R5 captured data kept", data_regs[7:0], 8'h9D);
    endtask

    task automatic t_drive();
        logic [7:0] v; logic oe;
        bus_read(1'b1, v, oe);
        chk("R6 drive during read", oe, 1);
        chk("R6 released after read", bus_d_oe, 0);
    endtask

    task automatic t_irq();
        logic [7:0] v; logic oe;
        bus_write(1'b0, 8'h01);
        pulse_event();
        chk("R7 irq set", irq_pull, 1);
        repeat (10) @(negedge clk);
        chk("R7 irq held idle", irq_pull, 1);
        bus_write(1'b1, 8'h42);
        bus_read(1'b1, v, oe);
        chk("R7 irq held over data access", irq_pull, 1);
        bus_read(1'b0, v, oe);
        chk("R8 mode read value", v, 8'h01);
        chk("R8 cleared by mode read", irq_pull, 0);
        pulse_event();
        chk("R7 irq set again", irq_pull, 1);
        bus_write(1'b0, 8'h01);
        chk("R8 cleared by mode write", irq_pull, 0);
    endtask

    task automatic t_disable();
        pulse_event();
        chk("R9 pending before disable", irq_pull, 1);
        bus_write(1'b0, 8'h00);
        chk("R9 off when disabled", irq_pull, 0);
        pulse_event();
        chk("R9 gated event", irq_pull, 0);
        bus_write(1'b0, 8'h01);
        repeat (3) @(negedge clk);
        chk("R9 event not remembered", irq_pull, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_mode();
        t_data();
        t_sel3();
        t_commit_edge();
        t_drive();
        t_irq();
        t_disable();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule